// File: doc/BRIEF.md
# Network Device Power State Controller

This block keeps track of the power-management state of a network interface attached to a host bus and decides, from that state, which of the interface's activities may run. Full power has two sub-states. After power-on reset the device is uninitialized. It becomes active after the host programs any of its base address registers. Software moves the device between full power and the sleep levels D1, D2 and D3 by writing a 2-bit requested state.

In D2 and D3 a configuration bit can let the device fall into a deep link-down sub-mode while the link is invalid. In that sub-mode link keepalive transmission stops, and the only thing the device waits for is the link becoming valid again. Wake-capable events are a wake-packet pulse from the receive path and a change of link status. Either event sets a wake request level, which is routed to a PME-style output on a conventional bus host or to a card-status-change output on a card-bus host. The level holds until software writes one to clear it or moves the device back to full power.

Top module: `netdev_pm_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, pm_state reads 0 (uninitialized), deep_mode, wake_req, pme_n_out and csc_out are 0, master_en and irq_en are 0, keepalive_en is 1, and cfg_only and low_power are 0.
- R2: In the uninitialized state (pm_state 0), a strobe on any bit of bar_wr with no request write moves pm_state to 1 (active) at the next edge. A strobe in any other state changes nothing.
- R3: The gating outputs depend on pm_state as follows. master_en and irq_en are 1 only in state 1. cfg_only is 1 in states 2, 3 and 4 (D1, D2, D3). low_power is 1 in states 3 and 4. keepalive_en is 1 everywhere except in the deep sub-mode.
- R4: A write with req_we moves pm_state at the next edge according to req_code. Code 01 gives D1 (pm_state 2), 10 gives D2 (3) and 11 gives D3 (4). Code 00 from D1, D2 or D3 gives the uninitialized state (0). Code 00 from state 0 or 1 leaves the state unchanged.
- R5: A wake_pkt pulse sets the wake request in states 0, 2, 3 and 4 outside the deep sub-mode. It has no effect in state 1 or in the deep sub-mode.
- R6: When link_wake_en is 1, a link status change sets the wake request in states 1 to 4. A link status change is link_valid differing from its value sampled at the previous edge; the sample reads 0 after reset. A link status change in state 0 does not set the wake request.
- R7: In D2 or D3 with deep_en at 1 and link_valid at 0 (and no request write), deep_mode rises at the next edge. With deep_en at 0 the device stays in normal D2/D3 behaviour even when the link is down.
- R8: The deep sub-mode ends at the next edge after link_valid returns to 1 (which also sets the wake request when link_wake_en is 1), after deep_en is cleared (no wake), or after any request write.
- R9: The wake request is a level. It clears on wake_clr, but a wake event in the same cycle as wake_clr wins. A D0 request taken from D1–D3 clears it regardless of events.
- R10: pme_n_out equals the wake request when host_cardbus is 0, and csc_out equals it when host_cardbus is 1. The unselected output is 0.
- R11: D3 behaves exactly as D2 for gating, wake and deep sub-mode; only the pm_state code (4 instead of 3) differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| req_we | input | 1 | Strobe: requested power state written |
| req_code | input | 2 | Requested state, 00=D0 01=D1 10=D2 11=D3 |
| bar_wr | input | NUM_BARS | Write strobes of the base address registers |
| link_valid | input | 1 | Link status, 1 = valid |
| wake_pkt | input | 1 | Pulse: wake packet recognised |
| deep_en | input | 1 | Enable for the deep link-down sub-mode |
| link_wake_en | input | 1 | Enable for wake on link status change |
| wake_clr | input | 1 | Write-one-to-clear of the wake request |
| host_cardbus | input | 1 | 1 = card-bus host, 0 = conventional bus host |
| pm_state | output | 3 | Current state: 0 uninit, 1 active, 2 D1, 3 D2, 4 D3 |
| deep_mode | output | 1 | Deep link-down sub-mode active |
| master_en | output | 1 | Bus mastering allowed |
| irq_en | output | 1 | Interrupts allowed |
| keepalive_en | output | 1 | Idle symbols and link pulses transmitted |
| cfg_only | output | 1 | Only configuration accesses serviced |
| low_power | output | 1 | Reduced-current sleep level |
| wake_req | output | 1 | Latched wake request level |
| pme_n_out | output | 1 | Wake request on a conventional bus host |
| csc_out | output | 1 | Wake request on a card-bus host |

## Verification
The delicate overlap is a wake event arriving in the same cycle as its clear. The bench pulses wake_pkt together with wake_clr in D1, and also raises link_valid in the same cycle wake_clr is written while in deep sub-mode. The wake request must stay set at the following edge. A second overlap puts a D0 request in the same cycle as a wake packet in D2, where the request must win and leave the level clear. A behavioural model updated on every edge judges all outputs, which also covers the deep sub-mode exit coinciding with a link-change wake.

// File: rtl/netdev_pm_pkg.sv
package netdev_pm_pkg;

    typedef enum logic [2:0] {
        PM_D0U = 3'd0,
        PM_D0A = 3'd1,
        PM_D1  = 3'd2,
        PM_D2  = 3'd3,
        PM_D3  = 3'd4
    } pm_state_e;

    localparam logic [1:0] REQ_D0 = 2'b00;
    localparam logic [1:0] REQ_D1 = 2'b01;
    localparam logic [1:0] REQ_D2 = 2'b10;

    typedef struct packed {
        logic master_en;
        logic irq_en;
        logic keepalive_en;
        logic cfg_only;
        logic low_power;
    } pm_gates_t;

    function automatic logic is_sleep(pm_state_e s);
        return (s == PM_D1) || (s == PM_D2) || (s == PM_D3);
    endfunction

    function automatic logic is_deep_capable(pm_state_e s);
        return (s == PM_D2) || (s == PM_D3);
    endfunction

    function automatic pm_state_e req_target(logic [1:0] code, pm_state_e cur);
        pm_state_e nxt;
        case (code)
            REQ_D0:  nxt = is_sleep(cur) ? PM_D0U : cur;
            REQ_D1:  nxt = PM_D1;
            REQ_D2:  nxt = PM_D2;
            default: nxt = PM_D3;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import netdev_pm_pkg::*;
#(
    parameter int NUM_BARS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_we,
    input  logic [1:0]          req_code,
    input  logic [NUM_BARS-1:0] bar_wr,
    input  logic                link_valid,
    input  logic                deep_en,
    output pm_state_e           state,
    output logic                deep,
    output logic                to_d0
);

    pm_state_e state_q;
    logic      deep_q;
    logic      any_bar;

    assign any_bar = |bar_wr;
    assign to_d0   = req_we && (req_code == REQ_D0) && is_sleep(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_D0U;
            deep_q  <= 1'b0;
        end else begin
            if (req_we) begin
                state_q <= req_target(req_code, state_q);
            end else if ((state_q == PM_D0U) && any_bar) begin
                state_q <= PM_D0A;
            end
            deep_q <= !req_we && is_deep_capable(state_q) && deep_en && !link_valid;
        end
    end

    assign state = state_q;
    assign deep  = deep_q;

    a_r2_bar_activates: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_D0U) && !req_we && any_bar |=> (state_q == PM_D0A));

    a_r4_d0_lands_uninit: assert property (@(posedge clk) disable iff (rst)
        to_d0 |=> (state_q == PM_D0U));

    a_r7_deep_in_d2_d3: assert property (@(posedge clk) disable iff (rst)
        deep_q |-> is_deep_capable(state_q));

    a_r8_deep_exit_on_link: assert property (@(posedge clk) disable iff (rst)
        deep_q && link_valid |=> !deep_q);

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
    import netdev_pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pm_state_e state,
    input  logic      deep,
    input  logic      to_d0,
    input  logic      link_valid,
    input  logic      link_wake_en,
    input  logic      wake_pkt,
    input  logic      wake_clr,
    output logic      wake
);

    logic link_q;
    logic wake_q;
    logic pkt_ev;
    logic link_ev;
    logic any_ev;

    assign pkt_ev  = wake_pkt && ((state == PM_D0U) || (is_sleep(state) && !deep));
    assign link_ev = link_wake_en && (link_valid != link_q) && (state != PM_D0U);
    assign any_ev  = pkt_ev || link_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            link_q <= link_valid;
            if (to_d0) begin
                wake_q <= 1'b0;
            end else if (any_ev) begin
                wake_q <= 1'b1;
            end else if (wake_clr) begin
                wake_q <= 1'b0;
            end
        end
    end

    assign wake = wake_q;

    a_r9_level_holds: assert property (@(posedge clk) disable iff (rst)
        wake_q && !wake_clr && !to_d0 |=> wake_q);

    a_r9_d0_clears: assert property (@(posedge clk) disable iff (rst)
        to_d0 |=> !wake_q);

    a_r5_active_pkt_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == PM_D0A) && !wake_q && wake_pkt && !link_ev |=> !wake_q);

endmodule

// File: rtl/pm_gate_decode.sv
module pm_gate_decode
    import netdev_pm_pkg::*;
(
    input  pm_state_e state,
    input  logic      deep,
    output pm_gates_t gates
);

    always_comb begin
        gates.master_en    = (state == PM_D0A);
        gates.irq_en       = (state == PM_D0A);
        gates.keepalive_en = !deep;
        gates.cfg_only     = is_sleep(state);
        gates.low_power    = is_deep_capable(state);
    end

endmodule

// File: rtl/netdev_pm_ctrl.sv
module netdev_pm_ctrl
    import netdev_pm_pkg::*;
#(
    parameter int NUM_BARS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_we,
    input  logic [1:0]          req_code,
    input  logic [NUM_BARS-1:0] bar_wr,
    input  logic                link_valid,
    input  logic                wake_pkt,
    input  logic                deep_en,
    input  logic                link_wake_en,
    input  logic                wake_clr,
    input  logic                host_cardbus,
    output logic [2:0]          pm_state,
    output logic                deep_mode,
    output logic                master_en,
    output logic                irq_en,
    output logic                keepalive_en,
    output logic                cfg_only,
    output logic                low_power,
    output logic                wake_req,
    output logic                pme_n_out,
    output logic                csc_out
);

    pm_state_e state;
    logic      deep;
    logic      to_d0;
    logic      wake;
    pm_gates_t gates;

    pm_state_fsm #(.NUM_BARS(NUM_BARS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_we     (req_we),
        .req_code   (req_code),
        .bar_wr     (bar_wr),
        .link_valid (link_valid),
        .deep_en    (deep_en),
        .state      (state),
        .deep       (deep),
        .to_d0      (to_d0)
    );

    pm_wake_ctrl u_wake (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .deep         (deep),
        .to_d0        (to_d0),
        .link_valid   (link_valid),
        .link_wake_en (link_wake_en),
        .wake_pkt     (wake_pkt),
        .wake_clr     (wake_clr),
        .wake         (wake)
    );

    pm_gate_decode u_dec (
        .state (state),
        .deep  (deep),
        .gates (gates)
    );

    assign pm_state     = state;
    assign deep_mode    = deep;
    assign master_en    = gates.master_en;
    assign irq_en       = gates.irq_en;
    assign keepalive_en = gates.keepalive_en;
    assign cfg_only     = gates.cfg_only;
    assign low_power    = gates.low_power;
    assign wake_req     = wake;
    assign pme_n_out    = wake && !host_cardbus;
    assign csc_out      = wake && host_cardbus;

    a_r10_one_route: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pme_n_out, csc_out}) && ((pme_n_out || csc_out) == wake_req));

    a_r3_sleep_no_master: assert property (@(posedge clk) disable iff (rst)
        cfg_only |-> !master_en && !irq_en);

    a_r7_deep_stops_keepalive: assert property (@(posedge clk) disable iff (rst)
        deep_mode |-> !keepalive_en && low_power);

endmodule

// File: tb/test_netdev_pm_ctrl.sv
module test_netdev_pm_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_we = 1'b0;
    logic [1:0] req_code = 2'b00;
    logic [2:0] bar_wr = 3'b000;
    logic       link_valid = 1'b1;
    logic       wake_pkt = 1'b0;
    logic       deep_en = 1'b0;
    logic       link_wake_en = 1'b1;
    logic       wake_clr = 1'b0;
    logic       host_cardbus = 1'b0;
    logic [2:0] pm_state;
    logic       deep_mode, master_en, irq_en, keepalive_en, cfg_only, low_power;
    logic       wake_req, pme_n_out, csc_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // behavioural model
    int m_st = 0;
    bit m_deep = 1'b0;
    bit m_wake = 1'b0;
    bit m_lprev = 1'b0;

    always #5 clk = ~clk;

    netdev_pm_ctrl i_netdev_pm_ctrl (
        .clk(clk), .rst(rst), .req_we(req_we), .req_code(req_code), .bar_wr(bar_wr),
        .link_valid(link_valid), .wake_pkt(wake_pkt), .deep_en(deep_en),
        .link_wake_en(link_wake_en), .wake_clr(wake_clr), .host_cardbus(host_cardbus),
        .pm_state(pm_state), .deep_mode(deep_mode), .master_en(master_en), .irq_en(irq_en),
        .keepalive_en(keepalive_en), .cfg_only(cfg_only), .low_power(low_power),
        .wake_req(wake_req), .pme_n_out(pme_n_out), .csc_out(csc_out)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_deep = 0; m_wake = 0; m_lprev = 0;
        end else begin
            bit ev_pkt, ev_link, go_d0;
            int nst;
            bit ndeep;
            ev_pkt  = wake_pkt && (m_st == 0 || (m_st >= 2 && !m_deep));
            ev_link = link_wake_en && (link_valid != m_lprev) && m_st != 0;
            go_d0   = req_we && req_code == 2'b00 && m_st >= 2;
            if (go_d0) m_wake = 0;
            else if (ev_pkt || ev_link) m_wake = 1;
            else if (wake_clr) m_wake = 0;
            nst = m_st;
            if (req_we) nst = (req_code == 0) ? (m_st >= 2 ? 0 : m_st) : int'(req_code) + 1;
            else if (m_st == 0 && bar_wr != 0) nst = 1;
            ndeep = !req_we && (m_st == 3 || m_st == 4) && deep_en && !link_valid;
            m_st = nst; m_deep = ndeep; m_lprev = link_valid;
        end
    end

    // per-clock comparison against the model, half a period after the edge
    always @(negedge clk) begin
        if (!finished) begin
            chk("R4", "pm_state", pm_state, m_st);
            chk("R7", "deep_mode", deep_mode, m_deep);
            chk("R3", "master_en", master_en, m_st == 1);
            chk("R3", "irq_en", irq_en, m_st == 1);
            chk("R3", "keepalive_en", keepalive_en, !m_deep);
            chk("R3", "cfg_only", cfg_only, m_st >= 2);
            chk("R3", "low_power", low_power, m_st >= 3);
            chk("R9", "wake_req", wake_req, m_wake);
            chk("R10", "pme_n_out", pme_n_out, m_wake && !host_cardbus);
            chk("R10", "csc_out", csc_out, m_wake && host_cardbus);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #3;
        end
    endtask

    task automatic request(logic [1:0] code);
        @(posedge clk); #3;
        req_we = 1'b1; req_code = code;
        @(posedge clk); #3;
        req_we = 1'b0;
    endtask

    task automatic pkt_pulse();
        @(posedge clk); #3;
        wake_pkt = 1'b1;
        @(posedge clk); #3;
        wake_pkt = 1'b0;
    endtask

    task automatic clr_pulse();
        @(posedge clk); #3;
        wake_clr = 1'b1;
        @(posedge clk); #3;
        wake_clr = 1'b0;
    endtask

    task automatic look();
        @(negedge clk); #1;
    endtask

    initial begin
        idle(3);
        look();
        chk("R1", "state in reset", pm_state, 0);
        chk("R1", "keepalive in reset", keepalive_en, 1);
        @(posedge clk); #3; rst = 1'b0;
        look();
        chk("R1", "state after reset", pm_state, 0);
        chk("R1", "master after reset", master_en, 0);
        chk("R1", "wake after reset", wake_req, 0);
        idle(2);
        // link change in uninitialized state: no wake (R6)
        link_valid = 1'b0; idle(2); link_valid = 1'b1; idle(2);
        look(); chk("R6", "no link wake in uninit", wake_req, 0);
        // base register strobe (R2)
        @(posedge clk); #3; bar_wr = 3'b100; @(posedge clk); #3; bar_wr = 3'b000;
        look(); chk("R2", "active after bar write", pm_state, 1);
        chk("R3", "master in active", master_en, 1);
        @(posedge clk); #3; bar_wr = 3'b011; @(posedge clk); #3; bar_wr = 3'b000;
        look(); chk("R2", "bar ignored when active", pm_state, 1);
        // D0 request in active: no change (R4)
        request(2'b00); look(); chk("R4", "D0 from active stays", pm_state, 1);
        // packet in active ignored (R5)
        pkt_pulse(); look(); chk("R5", "pkt ignored in active", wake_req, 0);
        // link change in active wakes (R6)
        @(posedge clk); #3; link_valid = 1'b0;
        look(); look(); chk("R6", "link wake in active", wake_req, 1);
        clr_pulse(); look(); chk("R9", "clear", wake_req, 0);
        link_valid = 1'b1; idle(1); clr_pulse();
        // D1 with packet, both routings (R10)
        request(2'b01); look(); chk("R4", "D1 code", pm_state, 2);
        chk("R3", "cfg only in D1", cfg_only, 1);
        pkt_pulse(); look(); chk("R5", "pkt wakes D1", wake_req, 1);
        chk("R10", "pme routed", pme_n_out, 1);
        host_cardbus = 1'b1; look(); chk("R10", "csc routed", csc_out, 1);
        chk("R10", "pme quiet", pme_n_out, 0);
        // event with clear in same cycle: event wins (R9)
        @(posedge clk); #3; wake_clr = 1'b1; wake_pkt = 1'b1;
        @(posedge clk); #3; wake_clr = 1'b0; wake_pkt = 1'b0;
        look(); chk("R9", "event beats clear", wake_req, 1);
        // D0 request clears, lands uninit (R4, R9)
        request(2'b00); look(); chk("R4", "D1 to uninit", pm_state, 0);
        chk("R9", "D0 clears wake", wake_req, 0);
        pkt_pulse(); look(); chk("R5", "pkt wakes uninit", wake_req, 1);
        clr_pulse(); host_cardbus = 1'b0;
        // D2 with deep disabled, link down (R7)
        request(2'b10); look(); chk("R4", "D2 code", pm_state, 3);
        link_valid = 1'b0; idle(3);
        look(); chk("R7", "no deep when disabled", deep_mode, 0);
        chk("R7", "keepalive kept", keepalive_en, 1);
        chk("R6", "link fall wakes D2", wake_req, 1);
        clr_pulse();
        // D0 request with simultaneous packet: request wins (R9)
        @(posedge clk); #3; req_we = 1'b1; req_code = 2'b00; wake_pkt = 1'b1;
        @(posedge clk); #3; req_we = 1'b0; wake_pkt = 1'b0;
        look(); chk("R9", "D0 beats event", wake_req, 0);
        request(2'b10);
        // deep entry (R7)
        deep_en = 1'b1; idle(2);
        look(); chk("R7", "deep entered", deep_mode, 1);
        chk("R7", "keepalive stopped", keepalive_en, 0);
        pkt_pulse(); look(); chk("R8", "pkt ignored in deep", wake_req, 0);
        // link up with clear in same cycle: exit and wake (R8, R9)
        @(posedge clk); #3; link_valid = 1'b1; wake_clr = 1'b1;
        @(posedge clk); #3; wake_clr = 1'b0;
        look(); chk("R8", "deep exit on link", deep_mode, 0);
        chk("R8", "wake on exit", wake_req, 1);
        clr_pulse();
        // D3 identical to D2 (R11)
        request(2'b11); look(); chk("R11", "D3 code", pm_state, 4);
        chk("R11", "low power in D3", low_power, 1);
        link_wake_en = 1'b0; link_valid = 1'b0; idle(2);
        look(); chk("R11", "deep in D3", deep_mode, 1);
        chk("R6", "no wake when disabled", wake_req, 0);
        @(posedge clk); #3; deep_en = 1'b0;
        look(); look(); chk("R8", "exit on disable", deep_mode, 0);
        chk("R8", "no wake on disable exit", wake_req, 0);
        pkt_pulse(); look(); chk("R11", "pkt wakes D3", wake_req, 1);
        link_wake_en = 1'b1; link_valid = 1'b1; idle(3);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule